// File: doc/BRIEF.md
# Run-Length Expander with Zigzag-to-Raster Reorder

This block sits after the variable-length decoder of an image or video decoding pipeline. It accepts one 8x8 block of coefficients as a stream of (run, level) pairs and turns it into exactly 64 quantized 8-bit coefficient values. The input pairs describe positions in zigzag scan order. The output leaves in ordinary row-major (raster) order, so the stage that follows sees the block as a plain 8x8 matrix.

Each pair skips `run` zero positions and then places `level` at the next scan position. A beat flagged as end-of-block closes the block, and every position that was not written reads back as zero. The block holds two 64-entry buffers. One is filled from the input while the other drains to the output, so a new block can be accepted while the previous one is still leaving. Both streams use valid/ready handshakes. The output marks the first and the last coefficient of every block.

Top module: `rlz_expand`

## Requirements
- R1: Every block that is closed produces exactly 64 output beats. `out_first` is 1 only on the first beat and `out_last` is 1 only on the 64th beat.
- R2: Scan index k is mapped to raster position row*8+col by the standard zigzag walk. The walk begins 0,1,8,16,9,2,3,10,17,24. Output beat p carries the value of the scan index whose raster position is p.
- R3: A non-end beat with run R skips R positions, which read out as zero. It places the level at scan index idx+R, and the next pair starts at idx+R+1.
- R4: Levels are 8-bit two's-complement values and pass to the output unchanged, including 127, -128 and -1.
- R5: A beat with `in_eob`=1 closes the block, and its run and level fields are ignored. Every scan index at or above the current one outputs zero. An end beat at index 0 gives 64 zeros.
- R6: A pair that lands on scan index 63 closes the block without an end beat. The next beat starts a new block.
- R7: If idx+run exceeds 63, the level is dropped and the block closes with only the values written before it. `err_overflow` becomes 1 and stays 1 until reset.
- R8: While one block waits at the output, a second block is accepted. `in_ready` is 0 only when both buffers hold closed blocks.
- R9: While `out_valid`=1 and `out_ready`=0, `out_valid` stays 1 and `out_coef` does not change.
- R10: During reset `out_valid`=0, `in_ready`=1 and `err_overflow`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high together with in_valid |
| in_run | input | 6 | Number of zero positions skipped before the level |
| in_level | input | 8 | Quantized coefficient level (two's complement) |
| in_eob | input | 1 | End-of-block beat; run and level ignored |
| out_valid | output | 1 | Output coefficient valid |
| out_ready | input | 1 | Downstream accepts the coefficient |
| out_coef | output | 8 | Coefficient in raster order |
| out_first | output | 1 | First coefficient of a block |
| out_last | output | 1 | Last coefficient of a block |
| err_overflow | output | 1 | Sticky flag: a run went past scan index 63 |

## Verification
The hardest case to reach from the ports is the one where both buffers are full. This needs one closed block held at the output while a second block completes behind it. The bench gets there by holding `out_ready` low, sending two short blocks, and then observing `in_ready` fall. It then releases the output with `out_ready` toggling every cycle, which also exercises the hold behaviour under stalls. The bench also sends a run that overflows after a level has already been placed, then sends a normal block behind it. This shows that truncation closes the block cleanly and that the error flag persists.

// File: rtl/rlz_pkg.sv
package rlz_pkg;

    localparam int COEF_W = 8;
    localparam int SIDE   = 8;
    localparam int N_POS  = SIDE * SIDE;
    localparam int POS_W  = $clog2(N_POS);
    localparam int IDX_W  = POS_W + 1;
    localparam int RUN_W  = POS_W;
    localparam int N_BANK = 2;

    typedef logic [COEF_W-1:0] coef_t;
    typedef logic [POS_W-1:0]  pos_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef struct packed {
        logic [RUN_W-1:0] run;
        coef_t            level;
        logic             eob;
    } rl_beat_t;

    typedef struct packed {
        logic  en;
        logic  bank;
        pos_t  addr;
        coef_t data;
    } wr_req_t;

    // Enumerate anti-diagonals; odd diagonals go down-left, even go up-right.
    function automatic pos_t scan_to_raster(pos_t k);
        int   n;
        pos_t res;
        n   = 0;
        res = '0;
        for (int s = 0; s < 2 * SIDE - 1; s++) begin
            for (int i = 0; i < SIDE; i++) begin
                int row;
                int col;
                row = (s % 2 == 1) ? i : SIDE - 1 - i;
                col = s - row;
                if (col >= 0 && col < SIDE) begin
                    if (n == int'(k)) res = pos_t'(row * SIDE + col);
                    n++;
                end
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/rlz_fill_ctrl.sv
module rlz_fill_ctrl
    import rlz_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              beat_valid,
    output logic              beat_ready,
    input  rl_beat_t          beat,
    input  logic [N_BANK-1:0] bank_full,
    output wr_req_t           wr,
    output logic              close_en,
    output logic              close_bank,
    output logic              err_sticky
);

    idx_t idx_q;
    logic bank_q;
    idx_t target;
    logic take;
    logic over;
    logic place;
    logic last_pos;

    always_comb begin
        beat_ready = !bank_full[bank_q];
        take       = beat_valid && beat_ready;
        target     = idx_q + idx_t'(beat.run);
        over       = !beat.eob && (target > idx_t'(N_POS - 1));
        place      = take && !beat.eob && !over;
        last_pos   = place && (target == idx_t'(N_POS - 1));
        close_en   = take && (beat.eob || over || last_pos);
        close_bank = bank_q;
        wr.en      = place;
        wr.bank    = bank_q;
        wr.addr    = scan_to_raster(target[POS_W-1:0]);
        wr.data    = beat.level;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q      <= '0;
            bank_q     <= 1'b0;
            err_sticky <= 1'b0;
        end else begin
            if (close_en) begin
                idx_q  <= '0;
                bank_q <= ~bank_q;
            end else if (place) begin
                idx_q <= target + idx_t'(1);
            end
            if (take && over) err_sticky <= 1'b1;
        end
    end

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        err_sticky |=> err_sticky);

    assert_idx_in_range_R3: assert property (@(posedge clk) disable iff (rst)
        idx_q < idx_t'(N_POS));

endmodule

// File: rtl/rlz_bank_store.sv
module rlz_bank_store
    import rlz_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           wr,
    input  logic              close_en,
    input  logic              close_bank,
    input  logic              release_en,
    input  logic              release_bank,
    input  logic              rd_bank,
    input  pos_t              rd_addr,
    output coef_t             rd_data,
    output logic [N_BANK-1:0] full
);

    coef_t bank_rd [N_BANK];

    for (genvar b = 0; b < N_BANK; b++) begin : g_bank
        coef_t            mem [N_POS];
        logic [N_POS-1:0] seen;
        logic             full_q;
        logic             wr_here;

        assign wr_here = wr.en && (wr.bank == 1'(b));

        always_ff @(posedge clk) begin
            if (wr_here) mem[wr.addr] <= wr.data;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                seen   <= '0;
                full_q <= 1'b0;
            end else if (release_en && release_bank == 1'(b)) begin
                seen   <= '0;
                full_q <= 1'b0;
            end else begin
                if (wr_here) seen[wr.addr] <= 1'b1;
                if (close_en && close_bank == 1'(b)) full_q <= 1'b1;
            end
        end

        assign bank_rd[b] = seen[rd_addr] ? mem[rd_addr] : '0;
        assign full[b]    = full_q;

        assert_single_write_R3: assert property (@(posedge clk) disable iff (rst)
            wr_here |-> !seen[wr.addr]);

        assert_no_close_on_full_R8: assert property (@(posedge clk) disable iff (rst)
            (close_en && close_bank == 1'(b)) |-> !full_q);

        assert_no_write_on_full_R8: assert property (@(posedge clk) disable iff (rst)
            wr_here |-> !full_q);
    end

    assign rd_data = bank_rd[rd_bank];

endmodule

// File: rtl/rlz_drain_ctrl.sv
module rlz_drain_ctrl
    import rlz_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_BANK-1:0] full,
    input  coef_t             rd_data,
    output logic              rd_bank,
    output pos_t              rd_addr,
    output logic              out_valid,
    input  logic              out_ready,
    output coef_t             out_coef,
    output logic              out_first,
    output logic              out_last,
    output logic              release_en,
    output logic              release_bank
);

    pos_t pos_q;
    logic bank_q;
    logic fire;

    always_comb begin
        rd_bank      = bank_q;
        rd_addr      = pos_q;
        out_valid    = full[bank_q];
        out_coef     = rd_data;
        out_first    = (pos_q == '0);
        out_last     = (pos_q == pos_t'(N_POS - 1));
        fire         = out_valid && out_ready;
        release_en   = fire && out_last;
        release_bank = bank_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= '0;
            bank_q <= 1'b0;
        end else if (fire) begin
            pos_q <= pos_q + pos_t'(1);
            if (out_last) bank_q <= ~bank_q;
        end
    end

    assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_coef) && $stable(pos_q)));

    assert_first_after_last_R1: assert property (@(posedge clk) disable iff (rst)
        (fire && out_last) |=> (!out_valid || out_first));

endmodule

// File: rtl/rlz_expand.sv
module rlz_expand
    import rlz_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [RUN_W-1:0]  in_run,
    input  logic [COEF_W-1:0] in_level,
    input  logic              in_eob,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [COEF_W-1:0] out_coef,
    output logic              out_first,
    output logic              out_last,
    output logic              err_overflow
);

    rl_beat_t          beat;
    wr_req_t           wr;
    logic              close_en;
    logic              close_bank;
    logic              release_en;
    logic              release_bank;
    logic              rd_bank;
    pos_t              rd_addr;
    coef_t             rd_data;
    logic [N_BANK-1:0] full;

    assign beat = '{run: in_run, level: in_level, eob: in_eob};

    rlz_fill_ctrl i_fill (
        .clk        (clk),
        .rst        (rst),
        .beat_valid (in_valid),
        .beat_ready (in_ready),
        .beat       (beat),
        .bank_full  (full),
        .wr         (wr),
        .close_en   (close_en),
        .close_bank (close_bank),
        .err_sticky (err_overflow)
    );

    rlz_bank_store i_store (
        .clk          (clk),
        .rst          (rst),
        .wr           (wr),
        .close_en     (close_en),
        .close_bank   (close_bank),
        .release_en   (release_en),
        .release_bank (release_bank),
        .rd_bank      (rd_bank),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .full         (full)
    );

    rlz_drain_ctrl i_drain (
        .clk          (clk),
        .rst          (rst),
        .full         (full),
        .rd_data      (rd_data),
        .rd_bank      (rd_bank),
        .rd_addr      (rd_addr),
        .out_valid    (out_valid),
        .out_ready    (out_ready),
        .out_coef     (out_coef),
        .out_first    (out_first),
        .out_last     (out_last),
        .release_en   (release_en),
        .release_bank (release_bank)
    );

    assert_ready_while_bank_free_R8: assert property (@(posedge clk) disable iff (rst)
        (full == '0) |-> in_ready);

endmodule

// File: tb/test_rlz_expand.sv
module test_rlz_expand;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic       in_ready;
    logic [5:0] in_run;
    logic [7:0] in_level;
    logic       in_eob;
    logic       out_valid;
    logic       out_ready;
    logic [7:0] out_coef;
    logic       out_first;
    logic       out_last;
    logic       err_overflow;

    always #5 clk = ~clk;

    rlz_expand i_rlz_expand (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_run       (in_run),
        .in_level     (in_level),
        .in_eob       (in_eob),
        .out_valid    (out_valid),
        .out_ready    (out_ready),
        .out_coef     (out_coef),
        .out_first    (out_first),
        .out_last     (out_last),
        .err_overflow (err_overflow)
    );

    int    checks = 0;
    int    errors = 0;
    int    zmap [64];
    int    inv  [64];
    int    m_blk[64];
    int    m_idx = 0;
    int    exp_q[$];
    string tag_q[$];
    string cur_tag = "R3";
    int    mon_beat = 0;
    bit    stall_prev = 1'b0;
    logic [7:0] prev_coef = '0;

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Zigzag walk by bouncing between edges.
    initial begin
        int r;
        int c;
        bit up;
        r = 0; c = 0; up = 1'b1;
        for (int k = 0; k < 64; k++) begin
            zmap[k] = r * 8 + c;
            if (up) begin
                if (c == 7)      begin r++; up = 1'b0; end
                else if (r == 0) begin c++; up = 1'b0; end
                else             begin r--; c++; end
            end else begin
                if (r == 7)      begin c++; up = 1'b1; end
                else if (c == 0) begin r++; up = 1'b1; end
                else             begin r++; c--; end
            end
        end
        for (int k = 0; k < 64; k++) inv[zmap[k]] = k;
        for (int k = 0; k < 64; k++) m_blk[k] = 0;
    end

    task automatic model_close();
        for (int p = 0; p < 64; p++) begin
            exp_q.push_back(m_blk[inv[p]]);
            tag_q.push_back(cur_tag);
        end
        for (int k = 0; k < 64; k++) m_blk[k] = 0;
        m_idx = 0;
    endtask

    task automatic send(int run, int level, bit eob);
        int t;
        in_run   = run[5:0];
        in_level = level[7:0];
        in_eob   = eob;
        in_valid = 1'b1;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1 in_valid = 1'b0;
        if (eob) begin
            model_close();
        end else begin
            t = m_idx + run;
            if (t > 63) begin
                model_close();
            end else begin
                m_blk[t] = level & 255;
                m_idx = t + 1;
                if (m_idx == 64) model_close();
            end
        end
    endtask

    task automatic wait_empty();
        while (exp_q.size() != 0) @(posedge clk);
        @(posedge clk);
        #1;
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (stall_prev) begin
                check(out_valid == 1'b1, "R9", "valid held", int'(out_valid), 1);
                check(out_coef == prev_coef, "R9", "coef held", int'(out_coef), int'(prev_coef));
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1", "unexpected beat", int'(out_coef), -1);
                end else begin
                    int    e;
                    string tg;
                    e  = exp_q.pop_front();
                    tg = tag_q.pop_front();
                    check(int'(out_coef) == e, tg, $sformatf("coef at raster %0d", mon_beat),
                          int'(out_coef), e);
                    check(out_first == (mon_beat == 0), "R1", "first flag", int'(out_first),
                          int'(mon_beat == 0));
                    check(out_last == (mon_beat == 63), "R1", "last flag", int'(out_last),
                          int'(mon_beat == 63));
                    mon_beat = (mon_beat + 1) % 64;
                end
            end
            stall_prev = out_valid && !out_ready;
            prev_coef  = out_coef;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R1 actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_run = '0; in_level = '0; in_eob = 1'b0; out_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R10", "reset out_valid", int'(out_valid), 0);
        check(in_ready == 1'b1, "R10", "reset in_ready", int'(in_ready), 1);
        check(err_overflow == 1'b0, "R10", "reset err", int'(err_overflow), 0);
        @(posedge clk);
        #1 rst = 1'b0; out_ready = 1'b1;

        cur_tag = "R3";
        send(0, 5, 0); send(0, 17, 0); send(2, 7, 0); send(10, 1, 0); send(0, 0, 1);

        cur_tag = "R5";
        send(17, 99, 1);
        send(3, 44, 0); send(9, 200, 1);

        cur_tag = "R4";
        send(0, 127, 0); send(0, -128, 0); send(1, -1, 0); send(0, 0, 1);

        cur_tag = "R2";
        for (int k = 0; k < 64; k++) send(0, k + 1, 0);

        cur_tag = "R6";
        send(62, 4, 0); send(0, -128, 0);
        wait_empty();
        check(err_overflow == 1'b0, "R7", "err before overflow", int'(err_overflow), 0);

        cur_tag = "R7";
        send(30, 2, 0); send(40, 3, 0);
        check(err_overflow == 1'b1, "R7", "err after overflow", int'(err_overflow), 1);
        send(1, -1, 0); send(0, 0, 1);
        wait_empty();
        check(err_overflow == 1'b1, "R7", "err sticky", int'(err_overflow), 1);

        cur_tag = "R8";
        out_ready = 1'b0;
        send(0, 11, 0); send(0, 0, 1);
        send(5, 22, 0); send(0, 0, 1);
        in_valid = 1'b1; in_run = '0; in_level = 8'd33; in_eob = 1'b0;
        repeat (3) @(negedge clk);
        check(in_ready == 1'b0, "R8", "in_ready with both full", int'(in_ready), 0);
        check(out_valid == 1'b1, "R8", "first block waiting", int'(out_valid), 1);
        @(posedge clk);
        #1 in_valid = 1'b0;
        while (exp_q.size() != 0) begin
            @(posedge clk);
            #1 out_ready = ~out_ready;
        end
        out_ready = 1'b1;
        repeat (3) @(posedge clk);
        check(out_valid == 1'b0, "R1", "idle after drain", int'(out_valid), 0);
        check(mon_beat == 0, "R1", "whole blocks", mon_beat, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule